// File: doc/BRIEF.md
# Instruction Byte Prefetch Queue

This block sits between an instruction cache (or memory port) and the first decode stage. It holds two 16-byte line slots and fetches whole lines on its own, without waiting for any downstream stage. Whenever a slot is free and no fetch is already in flight, it asks for the next sequential line. This keeps both slots full whenever the memory side allows it.

Decode sees a little-endian window of up to three bytes that starts at the current read offset. The window may run across the end of one slot into the next. Each cycle, decode reports how many bytes it used, from 0 to 15. When the read offset passes the end of a slot, that slot is freed and refilled at once.

A redirect empties both slots and moves the read offset to the target byte. It then starts fetching the line that contains the target. Each request carries a one-bit epoch tag. A response that arrives with a stale tag is thrown away.

Top module: `prefetch_queue`

## Requirements
- R1: After reset, `win_count` is 0 and a fill request for the line holding `RESET_ADDR` (line 0 by default) is raised with tag 0.
- R2: In the cycle after `redirect_valid`, `win_count` is 0, a fill request for line `redirect_addr[ADDR_W-1:4]` is raised, and `fill_req_tag` has inverted. A consume or response given in the redirect cycle has no effect.
- R3: Once a request is accepted (`fill_req_valid` and `fill_req_ready` both high), no new request is raised until the response with the matching tag has arrived.
- R4: While `fill_req_valid` is high and `fill_req_ready` is low, the request stays up and `fill_req_line` holds its value.
- R5: Byte k of `fill_rsp_data` (bits 8k+7..8k) is the byte at offset k of the line. Window byte i sits at `win_data[8i+7:8i]` and holds the byte at read pointer + i. `win_count` equals min(buffered bytes, 3). Window bytes at or beyond `win_count` read as zero.
- R6: The window spans the boundary between the two slots: with the read offset at 14 and the next line buffered, all three bytes are valid.
- R7: `consume_bytes` advances the read pointer by that many bytes. It must not exceed the number of buffered bytes. When the pointer crosses the end of a slot, that slot is freed and a request for the next sequential line follows.
- R8: A response whose tag differs from the current epoch is dropped. It buffers nothing, and it does not end an outstanding request.
- R9: A consume of 0 leaves the window unchanged.
- R10: While both slots hold data, no fill request is raised.
- R11: After a redirect to a target with a nonzero line offset, the first line response exposes only the bytes from that offset to the end of the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redirect_valid | input | 1 | Flush the slots and restart fetching at `redirect_addr` |
| redirect_addr | input | ADDR_W | Byte address to restart from |
| consume_bytes | input | 4 | Number of bytes decode used this cycle |
| fill_req_valid | output | 1 | A line fetch is requested |
| fill_req_ready | input | 1 | Memory side accepts the request |
| fill_req_line | output | ADDR_W-4 | Line address of the request |
| fill_req_tag | output | 1 | Epoch tag of the request |
| fill_rsp_valid | input | 1 | A line is returned |
| fill_rsp_tag | input | 1 | Epoch tag of the returned line |
| fill_rsp_data | input | 128 | Returned line, little-endian by byte |
| win_data | output | 24 | Decode window, three bytes |
| win_count | output | 2 | Number of valid window bytes (0 to 3) |

## Verification
The assertions check the request handshake on every cycle: one fetch outstanding at a time, a request held stable until it is accepted, and the flush and tag flip that follow a redirect. They also check that a stale response leaves the buffered byte count untouched, that the window count tracks the buffered byte count, and that decode never consumes more bytes than are buffered. Only the bench scenarios can show that the window carries the right bytes in the right order. These scenarios also cover a window that crosses from one slot into the other, a refill triggered by draining a slot, and the partial first line after a redirect to an unaligned target.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    localparam int unsigned LINE_BYTES = 16;
    localparam int unsigned OFF_W      = $clog2(LINE_BYTES);
    localparam int unsigned WIN_BYTES  = 3;
    localparam int unsigned CNT_W      = $clog2(WIN_BYTES + 1);
    localparam int unsigned AVAIL_W    = $clog2(2 * LINE_BYTES + 1);

    typedef logic [LINE_BYTES-1:0][7:0] line_t;
    typedef logic [OFF_W-1:0]           off_t;
endpackage

// File: rtl/pfq_avail.sv
module pfq_avail
    import pfq_pkg::*;
(
    input  logic               head_vld,
    input  logic               tail_vld,
    input  off_t               rd_off,
    output logic [AVAIL_W-1:0] avail
);
    logic [AVAIL_W-1:0] head_part;
    logic [AVAIL_W-1:0] tail_part;

    always_comb begin
        head_part = head_vld ? (AVAIL_W'(LINE_BYTES) - AVAIL_W'(rd_off)) : '0;
        tail_part = tail_vld ? AVAIL_W'(LINE_BYTES) : '0;
        avail     = head_part + tail_part;
    end
endmodule

// File: rtl/pfq_window.sv
module pfq_window
    import pfq_pkg::*;
(
    input  line_t                  head_line,
    input  line_t                  tail_line,
    input  off_t                   rd_off,
    input  logic [AVAIL_W-1:0]     avail,
    output logic [WIN_BYTES*8-1:0] win_data,
    output logic [CNT_W-1:0]       win_count
);
    for (genvar g = 0; g < WIN_BYTES; g++) begin : g_byte
        logic [OFF_W:0] pos;
        logic [7:0]     pick;
        always_comb begin
            pos  = {1'b0, rd_off} + (OFF_W+1)'(g);
            pick = pos[OFF_W] ? tail_line[pos[OFF_W-1:0]] : head_line[pos[OFF_W-1:0]];
            win_data[g*8 +: 8] = (avail > AVAIL_W'(g)) ? pick : 8'h00;
        end
    end

    assign win_count = (avail >= AVAIL_W'(WIN_BYTES)) ? CNT_W'(WIN_BYTES) : avail[CNT_W-1:0];
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
    import pfq_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    redirect_valid,
    input  logic [ADDR_W-1:0]       redirect_addr,
    input  logic [OFF_W-1:0]        consume_bytes,
    output logic                    fill_req_valid,
    input  logic                    fill_req_ready,
    output logic [ADDR_W-OFF_W-1:0] fill_req_line,
    output logic                    fill_req_tag,
    input  logic                    fill_rsp_valid,
    input  logic                    fill_rsp_tag,
    input  logic [LINE_BYTES*8-1:0] fill_rsp_data,
    output logic [WIN_BYTES*8-1:0]  win_data,
    output logic [CNT_W-1:0]        win_count
);
    localparam int unsigned LINE_W = ADDR_W - OFF_W;

    typedef struct packed {
        line_t [1:0]       lines;
        logic  [1:0]       vld;
        logic              head;
        off_t              rd_off;
        logic [LINE_W-1:0] fetch_line;
        logic              pending;
        logic              epoch;
    } state_t;

    state_t q, d;
    logic [OFF_W:0]     sum;
    logic               slot;
    logic [AVAIL_W-1:0] avail;

    assign fill_req_valid = !q.pending && !(&q.vld);
    assign fill_req_line  = q.fetch_line;
    assign fill_req_tag   = q.epoch;

    pfq_avail u_avail (
        .head_vld (q.vld[q.head]),
        .tail_vld (q.vld[~q.head]),
        .rd_off   (q.rd_off),
        .avail    (avail)
    );

    pfq_window u_window (
        .head_line (q.lines[q.head]),
        .tail_line (q.lines[~q.head]),
        .rd_off    (q.rd_off),
        .avail     (avail),
        .win_data  (win_data),
        .win_count (win_count)
    );

    always_comb begin
        d    = q;
        sum  = {1'b0, q.rd_off} + {1'b0, consume_bytes};
        slot = 1'b0;
        if (redirect_valid) begin
            d.vld        = '0;
            d.head       = 1'b0;
            d.rd_off     = redirect_addr[OFF_W-1:0];
            d.fetch_line = redirect_addr[ADDR_W-1:OFF_W];
            d.pending    = 1'b0;
            d.epoch      = ~q.epoch;
        end else begin
            // advance the read pointer; crossing a line end frees the head slot
            if (sum[OFF_W]) begin
                d.vld[q.head] = 1'b0;
                d.head        = ~q.head;
            end
            d.rd_off = sum[OFF_W-1:0];
            // accept a response only for the live epoch and an outstanding request
            if (q.pending && fill_rsp_valid && (fill_rsp_tag == q.epoch)) begin
                slot          = d.vld[d.head] ? ~d.head : d.head;
                d.lines[slot] = line_t'(fill_rsp_data);
                d.vld[slot]   = 1'b1;
                d.pending     = 1'b0;
            end
            if (fill_req_valid && fill_req_ready) begin
                d.pending    = 1'b1;
                d.fetch_line = q.fetch_line + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.lines      <= '0;
            q.vld        <= '0;
            q.head       <= 1'b0;
            q.rd_off     <= RESET_ADDR[OFF_W-1:0];
            q.fetch_line <= RESET_ADDR[ADDR_W-1:OFF_W];
            q.pending    <= 1'b0;
            q.epoch      <= 1'b0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker
    import pfq_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    redirect_valid,
    input logic [ADDR_W-OFF_W-1:0] redirect_line,
    input logic [OFF_W-1:0]        consume_bytes,
    input logic                    fill_req_valid,
    input logic                    fill_req_ready,
    input logic [ADDR_W-OFF_W-1:0] fill_req_line,
    input logic                    fill_req_tag,
    input logic                    fill_rsp_valid,
    input logic                    fill_rsp_tag,
    input logic [CNT_W-1:0]        win_count,
    input logic [AVAIL_W-1:0]      avail
);
    assert_single_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req_valid && fill_req_ready && !redirect_valid) |=> !fill_req_valid);

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req_valid && !fill_req_ready && !redirect_valid)
            |=> (fill_req_valid && $stable(fill_req_line)));

    assert_redirect_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> (win_count == '0 && fill_req_valid
            && fill_req_line == $past(redirect_line)
            && fill_req_tag != $past(fill_req_tag)));

    assert_consume_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_valid |-> (AVAIL_W'(consume_bytes) <= avail));

    assert_stale_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_rsp_valid && fill_rsp_tag != fill_req_tag && consume_bytes == '0 && !redirect_valid)
            |=> (avail == $past(avail)));

    assert_win_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        win_count == ((avail >= AVAIL_W'(WIN_BYTES)) ? CNT_W'(WIN_BYTES) : avail[CNT_W-1:0]));
endmodule

bind prefetch_queue pfq_checker #(.ADDR_W(ADDR_W)) u_pfq_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .redirect_valid (redirect_valid),
    .redirect_line  (redirect_addr[ADDR_W-1:pfq_pkg::OFF_W]),
    .consume_bytes  (consume_bytes),
    .fill_req_valid (fill_req_valid),
    .fill_req_ready (fill_req_ready),
    .fill_req_line  (fill_req_line),
    .fill_req_tag   (fill_req_tag),
    .fill_rsp_valid (fill_rsp_valid),
    .fill_rsp_tag   (fill_rsp_tag),
    .win_count      (win_count),
    .avail          (avail)
);

// File: tb/tb_prefetch_queue.sv
`timescale 1ns/1ps
module tb_prefetch_queue;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         redirect_valid = 1'b0;
    logic [31:0]  redirect_addr = '0;
    logic [3:0]   consume_bytes = '0;
    logic         fill_req_valid;
    logic         fill_req_ready = 1'b0;
    logic [27:0]  fill_req_line;
    logic         fill_req_tag;
    logic         fill_rsp_valid = 1'b0;
    logic         fill_rsp_tag = 1'b0;
    logic [127:0] fill_rsp_data = '0;
    logic [23:0]  win_data;
    logic [1:0]   win_count;

    int total = 0;
    int bad = 0;
    int ptr = 0;
    int endb = 0;
    bit epoch_m = 1'b0;
    bit pending_m = 1'b0;

    always #10 clk = ~clk;

    prefetch_queue dut (
        .clk, .rst_n, .redirect_valid, .redirect_addr, .consume_bytes,
        .fill_req_valid, .fill_req_ready, .fill_req_line, .fill_req_tag,
        .fill_rsp_valid, .fill_rsp_tag, .fill_rsp_data, .win_data, .win_count
    );

    // {consume[6:3], serve-after[2], expected count[1:0]}
    localparam logic [6:0] VEC [7] = '{
        {4'd0,  1'b0, 2'd3},
        {4'd5,  1'b0, 2'd3},
        {4'd9,  1'b0, 2'd3},
        {4'd2,  1'b1, 2'd3},
        {4'd15, 1'b0, 2'd3},
        {4'd15, 1'b1, 2'd2},
        {4'd2,  1'b0, 2'd3}
    };

    function automatic logic [7:0] mem_byte(input int a);
        logic [31:0] v;
        v = a;
        return v[7:0] ^ {v[11:8], v[11:8]} ^ 8'h5A;
    endfunction

    function automatic logic [127:0] mem_line(input int line);
        logic [127:0] l;
        for (int i = 0; i < 16; i++) l[i*8 +: 8] = mem_byte(line * 16 + i);
        return l;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_win(input string req);
        int cnt;
        int lines;
        int base;
        logic [23:0] exp;
        cnt = (endb > ptr) ? ((endb - ptr) < 3 ? endb - ptr : 3) : 0;
        exp = '0;
        for (int i = 0; i < cnt; i++) exp[i*8 +: 8] = mem_byte(ptr + i);
        base = ptr & ~15;
        lines = (endb > base) ? (endb - base) / 16 : 0;
        check({req, " count"}, 32'(win_count), 32'(cnt));
        check({req, " data"}, 32'(win_data), 32'(exp));
        check({req, " request"}, 32'(fill_req_valid), 32'(!pending_m && lines < 2));
    endtask

    task automatic accept(output int line, output bit tag);
        int guard = 0;
        while (!fill_req_valid && guard < 20) begin tick(); guard++; end
        line = int'(fill_req_line);
        tag = fill_req_tag;
        fill_req_ready = 1'b1;
        tick();
        fill_req_ready = 1'b0;
        pending_m = 1'b1;
    endtask

    task automatic respond(input int line, input bit tag);
        fill_rsp_valid = 1'b1;
        fill_rsp_tag = tag;
        fill_rsp_data = mem_line(line);
        tick();
        fill_rsp_valid = 1'b0;
        if (pending_m && tag == epoch_m) begin
            endb = (line + 1) * 16;
            pending_m = 1'b0;
        end
    endtask

    task automatic serve;
        int l;
        bit t;
        accept(l, t);
        respond(l, t);
    endtask

    task automatic do_consume(input int n);
        consume_bytes = 4'(n);
        tick();
        consume_bytes = '0;
        ptr += n;
    endtask

    task automatic do_redirect(input int a);
        redirect_valid = 1'b1;
        redirect_addr = a;
        tick();
        redirect_valid = 1'b0;
        ptr = a;
        endb = a & ~15;
        epoch_m = ~epoch_m;
        pending_m = 1'b0;
    endtask

    initial begin
        #2000000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int l;
        bit t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 count", 32'(win_count), 0);
        check("R1 request", 32'(fill_req_valid), 1);
        check("R1 line", 32'(fill_req_line), 0);
        check("R1 tag", 32'(fill_req_tag), 0);

        // R4: request held while not ready
        repeat (3) begin
            tick();
            check("R4 held", 32'(fill_req_valid), 1);
            check("R4 line", 32'(fill_req_line), 0);
        end

        // R3: no second request until the response
        accept(l, t);
        repeat (3) begin
            check("R3 quiet", 32'(fill_req_valid), 0);
            tick();
        end
        respond(l, t);
        check_win("R5 first line");
        serve();
        check_win("R10 both full");

        // table walk: R5 R6 R7 R9 R10
        for (int k = 0; k < 7; k++) begin
            do_consume(int'(VEC[k][6:3]));
            check("R7 table count", 32'(win_count), 32'(VEC[k][1:0]));
            check_win("R5/R6/R7/R9 table");
            if (VEC[k][2]) begin
                serve();
                check_win("R7 refill");
            end
        end

        // drain to leave one line buffered, put a request in flight
        do_consume(15);
        check_win("R7 drain");
        accept(l, t);
        check("R7 next line", 32'(l), 4);

        // R2: redirect to an unaligned target
        do_redirect(32'h10E);
        check("R2 count", 32'(win_count), 0);
        check("R2 request", 32'(fill_req_valid), 1);
        check("R2 line", 32'(fill_req_line), 32'h10);
        check("R2 tag", 32'(fill_req_tag), 1);

        // R8: late response of the old epoch is dropped
        respond(4, 1'b0);
        check_win("R8 late old");
        accept(l, t);
        respond(l, 1'b0);
        check_win("R8 wrong tag");
        check("R8 still pending", 32'(fill_req_valid), 0);

        // R11: only bytes from the target offset
        respond(l, t);
        check("R11 count", 32'(win_count), 2);
        check_win("R11 partial");
        serve();
        check_win("R6 straddle after redirect");
        do_consume(2);
        check_win("R7 drain partial line");
        serve();
        check("R10 no request", 32'(fill_req_valid), 0);
        check_win("R10 full");
        do_consume(0);
        check_win("R9 zero consume");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule